// File: doc/BRIEF.md
# Cyclic Crossbar Connection Arbiter

This block schedules circuit-switched connections through an N-by-N crossbar that links a set of clusters. Time is divided into communication cycles, and a single-clock end-of-transmission pulse marks each cycle boundary. While a cycle runs, each cluster may hand the arbiter one connection request naming its own transmit link (the source) and the receive link it wants to reach (the destination). Accepted requests join one pending list kept in arrival order.

On the boundary pulse the arbiter walks the pending list from oldest to newest. It grants every request whose source transmit link and destination receive link are both still free in the cycle being built. Requests that lose on either link stay in the list, ahead of anything that arrives later. The results are loaded into registers that stay unchanged for the whole next cycle: a transmit grant and destination field for each source, a receive grant for each destination, and a crossbar select word per destination that gives the source driving it. A done flag marks the clock in which these registers are fresh. Malformed, duplicate and overflow requests are refused, and the refusal shows in a status bit for the requesting cluster.

Top module: `xbar_cycle_arbiter`

## Requirements
- R1: After reset, all grant bits, destination fields, select words, reject status bits and the done flag read zero.
- R2: A request accepted during a cycle has no effect on the grant outputs until the next boundary pulse. Grant outputs change only on the clock edge that samples the boundary pulse, and then hold until the next pulse.
- R3: `done_o` is high for exactly the one clock that follows each clock in which `eot_i` is high, and low otherwise.
- R4: Pending requests are examined oldest first. A request left over from an earlier cycle is considered before any request that arrived after it.
- R5: A request whose destination receive link is already granted to an older request in the same scan is not granted, and it stays pending for later cycles.
- R6: A request whose source transmit link is already granted to an older request in the same scan is not granted, and it stays pending for later cycles.
- R7: Mailbox encoding. For a granted connection s to d, `tx_grant_o[s]` and `rx_grant_o[d]` are 1, `tx_dst_o[s*IDW +: IDW]` equals d, and `xbar_sel_o[d*IDW +: IDW]` equals s. Fields of ungranted sources and destinations are 0.
- R8: A request with source equal to destination, or with a destination of N or above, is not queued and sets `rej_bad_o[src]`.
- R9: A second request from a source that already had a request accepted in the same cycle is not queued and sets `rej_bad_o[src]`.
- R10: A valid request that arrives when QDEPTH requests are already pending is not queued and sets `rej_full_o[src]`.
- R11: Reject status bits are cleared by the boundary pulse. A rejection caused by a request presented in the same clock as the pulse still sets its bit.
- R12: A request presented in the same clock as the boundary pulse belongs to the new cycle. It is not arbitrated by that pulse, and it counts as that source's one request for the new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eot_i | input | 1 | Cycle-boundary pulse, one clock wide |
| req_valid_i | input | 1 | Connection request strobe |
| req_src_i | input | IDW | Requesting cluster (source transmit link) |
| req_dst_i | input | IDW | Requested destination receive link |
| done_o | output | 1 | Mailboxes freshly loaded |
| tx_grant_o | output | N | Transmit grant per source |
| tx_dst_o | output | N*IDW | Granted destination per source |
| rx_grant_o | output | N | Receive grant per destination |
| xbar_sel_o | output | N*IDW | Source selected per destination |
| rej_bad_o | output | N | Malformed or duplicate request status per cluster |
| rej_full_o | output | N | Queue-full rejection status per cluster |

## Verification
A fault in the pending list shows up at the grant registers on the first boundary after the fault. A dropped entry shows as a connection that never appears. A corrupted entry or a broken compaction order shows as the wrong source in a select word, or as a loser granted ahead of an older request. The scenarios therefore drain conflicted lists over several boundaries and check the order in which the grants appear. A fault in the scan's link masks shows at once, in the same mailbox load, as a receive grant without a matching transmit grant or as two grants on one link. A fault in the per-cycle tracking shows in the reject status bits one clock after the offending request.

// File: rtl/xca_pkg.sv
package xca_pkg;
  typedef enum logic [1:0] {
    RSN_NONE = 2'd0,
    RSN_OK   = 2'd1,
    RSN_BAD  = 2'd2,
    RSN_FULL = 2'd3
  } rsn_e;
endpackage

// File: rtl/xca_intake.sv
module xca_intake
  import xca_pkg::*;
#(
  parameter int N      = 20,
  parameter int IDW    = 5,
  parameter int QDEPTH = 8,
  parameter int CW     = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           eot_i,
  input  logic           req_valid_i,
  input  logic [IDW-1:0] req_src_i,
  input  logic [IDW-1:0] req_dst_i,
  input  logic [CW-1:0]  base_cnt_i,
  output logic           accept_o,
  output logic [N-1:0]   rej_bad_o,
  output logic [N-1:0]   rej_full_o
);
  logic [N-1:0] sent_q, sent_d, bad_q, bad_d, full_q, full_d;
  logic [N-1:0] src_oh, sent_eff;
  logic         src_ok, dst_ok;
  rsn_e         rsn;

  always_comb begin
    src_ok = int'(req_src_i) < N;
    dst_ok = int'(req_dst_i) < N;
    src_oh = '0;
    if (src_ok) src_oh[req_src_i] = 1'b1;
    sent_eff = eot_i ? '0 : sent_q;
    if (!req_valid_i || !src_ok)
      rsn = RSN_NONE;
    else if (!dst_ok || req_src_i == req_dst_i || (sent_eff & src_oh) != '0)
      rsn = RSN_BAD;
    else if (base_cnt_i >= CW'(QDEPTH))
      rsn = RSN_FULL;
    else
      rsn = RSN_OK;
    accept_o = (rsn == RSN_OK);
    sent_d = sent_eff | (accept_o ? src_oh : '0);
    bad_d  = (eot_i ? '0 : bad_q)  | ((rsn == RSN_BAD)  ? src_oh : '0);
    full_d = (eot_i ? '0 : full_q) | ((rsn == RSN_FULL) ? src_oh : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '0;
      bad_q  <= '0;
      full_q <= '0;
    end else begin
      sent_q <= sent_d;
      bad_q  <= bad_d;
      full_q <= full_d;
    end
  end

  assign rej_bad_o  = bad_q;
  assign rej_full_o = full_q;
endmodule

// File: rtl/xca_queue.sv
module xca_queue #(
  parameter int N      = 20,
  parameter int IDW    = 5,
  parameter int QDEPTH = 8,
  parameter int CW     = 4,
  parameter int QIW    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           eot_i,
  input  logic           push_i,
  input  logic [IDW-1:0] push_src_i,
  input  logic [IDW-1:0] push_dst_i,
  output logic [CW-1:0]  base_cnt_o,
  output logic [N-1:0]   gnt_tx_o,
  output logic [N*IDW-1:0] gnt_txdst_o,
  output logic [N-1:0]   gnt_rx_o,
  output logic [N*IDW-1:0] gnt_sel_o
);
  logic [IDW-1:0] q_src [QDEPTH];
  logic [IDW-1:0] q_dst [QDEPTH];
  logic [IDW-1:0] c_src [QDEPTH];
  logic [IDW-1:0] c_dst [QDEPTH];
  logic [IDW-1:0] n_src [QDEPTH];
  logic [IDW-1:0] n_dst [QDEPTH];
  logic [CW-1:0]  cnt_q, c_cnt, n_cnt, wc;
  logic [QDEPTH-1:0] live, win;
  logic [N-1:0]   tb, rb;
  logic           store_en;

  for (genvar i = 0; i < QDEPTH; i++) begin : g_live
    assign live[i] = (cnt_q > CW'(i));
  end

  // oldest-first scan, building link masks for the coming cycle
  always_comb begin
    tb = '0;
    rb = '0;
    win = '0;
    gnt_txdst_o = '0;
    gnt_sel_o = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (live[i] && !tb[q_src[i]] && !rb[q_dst[i]]) begin
        win[i] = 1'b1;
        tb[q_src[i]] = 1'b1;
        rb[q_dst[i]] = 1'b1;
        gnt_txdst_o[q_src[i]*IDW +: IDW] = q_dst[i];
        gnt_sel_o[q_dst[i]*IDW +: IDW]   = q_src[i];
      end
    end
    gnt_tx_o = tb;
    gnt_rx_o = rb;
  end

  // remove winners, keeping losers in order
  always_comb begin
    c_src = q_src;
    c_dst = q_dst;
    c_cnt = cnt_q;
    wc = '0;
    if (eot_i) begin
      for (int i = 0; i < QDEPTH; i++) begin
        if (live[i] && !win[i]) begin
          c_src[wc[QIW-1:0]] = q_src[i];
          c_dst[wc[QIW-1:0]] = q_dst[i];
          wc = wc + 1'b1;
        end
      end
      c_cnt = wc;
    end
  end

  assign base_cnt_o = c_cnt;

  // append the newly accepted request behind the survivors
  always_comb begin
    n_src = c_src;
    n_dst = c_dst;
    n_cnt = c_cnt;
    if (push_i && c_cnt < CW'(QDEPTH)) begin
      n_src[c_cnt[QIW-1:0]] = push_src_i;
      n_dst[c_cnt[QIW-1:0]] = push_dst_i;
      n_cnt = c_cnt + 1'b1;
    end
  end

  assign store_en = eot_i | push_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= n_cnt;
  end

  always_ff @(posedge clk) begin
    if (store_en) begin
      q_src <= n_src;
      q_dst <= n_dst;
    end
  end
endmodule

// File: rtl/xca_mailbox.sv
module xca_mailbox #(
  parameter int N   = 20,
  parameter int IDW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [N-1:0]     tx_i,
  input  logic [N*IDW-1:0] txdst_i,
  input  logic [N-1:0]     rx_i,
  input  logic [N*IDW-1:0] sel_i,
  output logic             done_o,
  output logic [N-1:0]     tx_grant_o,
  output logic [N*IDW-1:0] tx_dst_o,
  output logic [N-1:0]     rx_grant_o,
  output logic [N*IDW-1:0] xbar_sel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_grant_o <= '0;
      tx_dst_o   <= '0;
      rx_grant_o <= '0;
      xbar_sel_o <= '0;
    end else if (load_i) begin
      tx_grant_o <= tx_i;
      tx_dst_o   <= txdst_i;
      rx_grant_o <= rx_i;
      xbar_sel_o <= sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= load_i;
  end
endmodule

// File: rtl/xbar_cycle_arbiter.sv
module xbar_cycle_arbiter #(
  parameter int N      = 20,
  parameter int QDEPTH = 8,
  localparam int IDW   = $clog2(N),
  localparam int CW    = $clog2(QDEPTH + 1),
  localparam int QIW   = $clog2(QDEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eot_i,
  input  logic             req_valid_i,
  input  logic [IDW-1:0]   req_src_i,
  input  logic [IDW-1:0]   req_dst_i,
  output logic             done_o,
  output logic [N-1:0]     tx_grant_o,
  output logic [N*IDW-1:0] tx_dst_o,
  output logic [N-1:0]     rx_grant_o,
  output logic [N*IDW-1:0] xbar_sel_o,
  output logic [N-1:0]     rej_bad_o,
  output logic [N-1:0]     rej_full_o
);
  logic             rst_s1, rst_s2;
  logic             accept;
  logic [CW-1:0]    base_cnt;
  logic [N-1:0]     g_tx, g_rx;
  logic [N*IDW-1:0] g_txdst, g_sel;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  xca_intake #(.N(N), .IDW(IDW), .QDEPTH(QDEPTH), .CW(CW)) intake_i (
    .clk(clk), .rst_n(rst_s2), .eot_i(eot_i),
    .req_valid_i(req_valid_i), .req_src_i(req_src_i), .req_dst_i(req_dst_i),
    .base_cnt_i(base_cnt), .accept_o(accept),
    .rej_bad_o(rej_bad_o), .rej_full_o(rej_full_o)
  );

  xca_queue #(.N(N), .IDW(IDW), .QDEPTH(QDEPTH), .CW(CW), .QIW(QIW)) queue_i (
    .clk(clk), .rst_n(rst_s2), .eot_i(eot_i),
    .push_i(accept), .push_src_i(req_src_i), .push_dst_i(req_dst_i),
    .base_cnt_o(base_cnt), .gnt_tx_o(g_tx), .gnt_txdst_o(g_txdst),
    .gnt_rx_o(g_rx), .gnt_sel_o(g_sel)
  );

  xca_mailbox #(.N(N), .IDW(IDW)) mbox_i (
    .clk(clk), .rst_n(rst_s2), .load_i(eot_i),
    .tx_i(g_tx), .txdst_i(g_txdst), .rx_i(g_rx), .sel_i(g_sel),
    .done_o(done_o), .tx_grant_o(tx_grant_o), .tx_dst_o(tx_dst_o),
    .rx_grant_o(rx_grant_o), .xbar_sel_o(xbar_sel_o)
  );
endmodule

// File: rtl/xca_checker.sv
module xca_checker #(
  parameter int N   = 20,
  parameter int IDW = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eot_i,
  input logic             req_valid_i,
  input logic [IDW-1:0]   req_src_i,
  input logic [IDW-1:0]   req_dst_i,
  input logic             done_o,
  input logic [N-1:0]     tx_grant_o,
  input logic [N*IDW-1:0] tx_dst_o,
  input logic [N-1:0]     rx_grant_o,
  input logic [N*IDW-1:0] xbar_sel_o,
  input logic [N-1:0]     rej_bad_o,
  input logic [N-1:0]     rej_full_o
);
  // R2
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eot_i |=> ($stable(tx_grant_o) && $stable(rx_grant_o) && $stable(xbar_sel_o)));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_i |=> done_o);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eot_i |=> !done_o);

  // R5
  grant_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tx_grant_o) == $countones(rx_grant_o));

  // R8
  same_link_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && int'(req_src_i) < N && req_src_i == req_dst_i)
      |=> rej_bad_o[$past(req_src_i)]);

  // R11
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_i && !req_valid_i) |=> (rej_bad_o == '0 && rej_full_o == '0));

  for (genvar d = 0; d < N; d++) begin : g_pair
    logic [IDW-1:0] s_d;
    assign s_d = xbar_sel_o[d*IDW +: IDW];
    // R7
    xbar_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_grant_o[d] |-> (tx_grant_o[s_d] && tx_dst_o[s_d*IDW +: IDW] == IDW'(d)));
  end
endmodule

bind xbar_cycle_arbiter xca_checker #(.N(N), .IDW(IDW)) chk_i (
  .clk(clk), .rst_n(rst_n), .eot_i(eot_i), .req_valid_i(req_valid_i),
  .req_src_i(req_src_i), .req_dst_i(req_dst_i), .done_o(done_o),
  .tx_grant_o(tx_grant_o), .tx_dst_o(tx_dst_o), .rx_grant_o(rx_grant_o),
  .xbar_sel_o(xbar_sel_o), .rej_bad_o(rej_bad_o), .rej_full_o(rej_full_o)
);

// File: tb/xbar_cycle_arbiter_tb.sv
`timescale 1ns/1ps
module xbar_cycle_arbiter_tb_top;
  localparam int N = 20;
  localparam int QDEPTH = 8;
  localparam int IDW = $clog2(N);

  logic clk, rst_n, eot_i, req_valid_i;
  logic [IDW-1:0] req_src_i, req_dst_i;
  logic done_o;
  logic [N-1:0] tx_grant_o, rx_grant_o, rej_bad_o, rej_full_o;
  logic [N*IDW-1:0] tx_dst_o, xbar_sel_o;
  int checks, errors;

  xbar_cycle_arbiter #(.N(N), .QDEPTH(QDEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .eot_i(eot_i), .req_valid_i(req_valid_i),
    .req_src_i(req_src_i), .req_dst_i(req_dst_i), .done_o(done_o),
    .tx_grant_o(tx_grant_o), .tx_dst_o(tx_dst_o), .rx_grant_o(rx_grant_o),
    .xbar_sel_o(xbar_sel_o), .rej_bad_o(rej_bad_o), .rej_full_o(rej_full_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int bit_of(int i);
    return 1 << i;
  endfunction
  function automatic int sel_of(int d);
    return int'(xbar_sel_o[d*IDW +: IDW]);
  endfunction
  function automatic int dst_of(int s);
    return int'(tx_dst_o[s*IDW +: IDW]);
  endfunction

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic send(int s, int d);
    req_valid_i = 1'b1; req_src_i = IDW'(s); req_dst_i = IDW'(d);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask
  task automatic boundary();
    eot_i = 1'b1;
    @(negedge clk);
    eot_i = 1'b0;
  endtask
  task automatic send_at_boundary(int s, int d);
    eot_i = 1'b1; req_valid_i = 1'b1; req_src_i = IDW'(s); req_dst_i = IDW'(d);
    @(negedge clk);
    eot_i = 1'b0; req_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "tx_grant", int'(tx_grant_o), 0);
    chk("R1", "rx_grant", int'(rx_grant_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "rej", int'(rej_bad_o | rej_full_o), 0);
    chk("R1", "sel/dst", int'(|{xbar_sel_o, tx_dst_o}), 0);
  endtask

  task automatic t_single();
    send(2, 5);
    chk("R2", "grant before boundary", int'(tx_grant_o), 0);
    boundary();
    chk("R3", "done after boundary", int'(done_o), 1);
    chk("R7", "tx_grant", int'(tx_grant_o), bit_of(2));
    chk("R7", "rx_grant", int'(rx_grant_o), bit_of(5));
    chk("R7", "sel[5]", sel_of(5), 2);
    chk("R7", "dst[2]", dst_of(2), 5);
    chk("R7", "sel[0] unused", sel_of(0), 0);
    @(negedge clk);
    chk("R3", "done one clock", int'(done_o), 0);
    chk("R2", "grant held", int'(tx_grant_o), bit_of(2));
    boundary();
    chk("R2", "empty cycle", int'(tx_grant_o), 0);
  endtask

  task automatic t_rx_conflict();
    send(1, 3); send(4, 3); send(6, 7);
    boundary();
    chk("R5", "first tx", int'(tx_grant_o), bit_of(1) | bit_of(6));
    chk("R5", "first rx", int'(rx_grant_o), bit_of(3) | bit_of(7));
    chk("R5", "sel[3]", sel_of(3), 1);
    send(9, 3);
    boundary();
    chk("R4", "older loser first", int'(tx_grant_o), bit_of(4));
    chk("R4", "sel[3] second", sel_of(3), 4);
    boundary();
    chk("R4", "newest last", int'(tx_grant_o), bit_of(9));
    chk("R4", "sel[3] third", sel_of(3), 9);
    boundary();
    chk("R5", "drained", int'(tx_grant_o), 0);
  endtask

  task automatic t_tx_conflict();
    send(2, 5); send(7, 5);
    boundary();
    chk("R5", "tx", int'(tx_grant_o), bit_of(2));
    send(7, 8);
    boundary();
    chk("R6", "old 7 wins", int'(tx_grant_o), bit_of(7));
    chk("R6", "dst[7]", dst_of(7), 5);
    chk("R6", "rx only 5", int'(rx_grant_o), bit_of(5));
    boundary();
    chk("R6", "dst[7] next", dst_of(7), 8);
    chk("R6", "rx 8", int'(rx_grant_o), bit_of(8));
    boundary();
  endtask

  task automatic t_bad();
    send(3, 3);
    chk("R8", "same link", int'(rej_bad_o), bit_of(3));
    send(4, 25);
    chk("R8", "dst out of range", int'(rej_bad_o), bit_of(3) | bit_of(4));
    boundary();
    chk("R8", "nothing queued", int'(tx_grant_o), 0);
    chk("R11", "cleared", int'(rej_bad_o), 0);
  endtask

  task automatic t_dup();
    send(1, 2); send(1, 4);
    chk("R9", "dup status", int'(rej_bad_o), bit_of(1));
    boundary();
    chk("R9", "first kept", dst_of(1), 2);
    chk("R9", "second dropped", int'(rx_grant_o), bit_of(2));
    boundary();
  endtask

  task automatic t_full();
    for (int s = 0; s < QDEPTH; s++) send(s, 19);
    chk("R10", "no full yet", int'(rej_full_o), 0);
    send(8, 19);
    chk("R10", "full status", int'(rej_full_o), bit_of(8));
    boundary();
    chk("R10", "first", int'(tx_grant_o), bit_of(0));
    chk("R11", "full cleared", int'(rej_full_o), 0);
    for (int k = 1; k < QDEPTH; k++) begin
      boundary();
      chk("R4", "drain order", sel_of(19), k);
    end
    boundary();
    chk("R10", "overflow never queued", int'(tx_grant_o), 0);
  endtask

  task automatic t_same_clock();
    send_at_boundary(5, 6);
    chk("R12", "not arbitrated now", int'(tx_grant_o), 0);
    send(5, 9);
    chk("R12", "counts in new cycle", int'(rej_bad_o), bit_of(5));
    boundary();
    chk("R12", "granted next", int'(tx_grant_o), bit_of(5));
    chk("R12", "dst[5]", dst_of(5), 6);
    send_at_boundary(3, 3);
    chk("R11", "reject at boundary kept", int'(rej_bad_o), bit_of(3));
    boundary();
    chk("R11", "cleared later", int'(rej_bad_o), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; eot_i = 1'b0; req_valid_i = 1'b0;
    req_src_i = '0; req_dst_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_rx_conflict();
    t_tx_conflict();
    t_bad();
    t_dup();
    t_full();
    t_same_clock();
    finish_run();
  end
endmodule